// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

This block holds an eight-bit word that, on each rising clock edge, can be kept as it is, moved one place toward the high end, moved one place toward the low end, or replaced by the value on a parallel bus. Two select inputs pick the operation. The parallel bus serves as both input and output. The register drives its contents onto the bus through output drivers. In load mode the block turns those drivers off, so an external source can place the new word on the same wires.

The bus is modelled as three signals: a captured input, a driven output and a driver-enable. A chip-level pad or tri-state cell can join them into one shared net. Two active-low enables can also switch the drivers off, and register operation continues while they are off. Two serial outputs, one for each end bit, stay valid at all times. Registers can therefore be chained into longer words by wiring each end output to the neighbouring register's serial input. An active-low reset clears the word as soon as it is asserted. Its release is synchronised to the clock.

Top module: `ushreg_bus`

## Requirements
- R1: With select inputs {sel_hi, sel_lo} = 00 (hold), the word keeps its value across rising clock edges.
- R2: With {sel_hi, sel_lo} = 01 (shift up), each rising edge moves bit i into bit i+1, fills bit 0 from ser_in_lo, and drops the old bit 7.
- R3: With {sel_hi, sel_lo} = 10 (shift down), each rising edge moves bit i+1 into bit i, fills bit 7 from ser_in_hi, and drops the old bit 0.
- R4: With {sel_hi, sel_lo} = 11 (load), each rising edge copies bus_in into the word.
- R5: Driving rst_n low clears the word at once, without waiting for a clock edge, whatever the selects and the clock do. After rst_n rises, the first edge that changes the word is the third rising edge.
- R6: bus_oe is 1 only when oe_a_n and oe_b_n are both 0 and the mode is not load. It follows its inputs combinationally.
- R7: While bus_oe is 1, bus_out equals the current word. While bus_oe is 0, bus_out is all zeros.
- R8: The enables act only on the drivers. Hold, shift, load and reset behave the same whether the drivers are on or off.
- R9: ser_out_lo always equals bit 0 of the word and ser_out_hi always equals bit 7, whatever the enables or the mode.
- R10: In a chain of two registers, the lower one's ser_out_hi drives the upper one's ser_in_lo, and the upper one's ser_out_lo drives the lower one's ser_in_hi. With shared selects, the pair shifts and holds as a single sixteen-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the word changes on its rising edge |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, releases synchronously |
| sel_lo | input | 1 | Mode select, low bit |
| sel_hi | input | 1 | Mode select, high bit |
| ser_in_lo | input | 1 | Serial bit entering bit 0 in shift-up mode |
| ser_in_hi | input | 1 | Serial bit entering bit 7 in shift-down mode |
| oe_a_n | input | 1 | Active-low bus driver enable, first |
| oe_b_n | input | 1 | Active-low bus driver enable, second |
| bus_in | input | 8 | Value sampled from the shared bus |
| bus_out | output | 8 | Value driven onto the shared bus |
| bus_oe | output | 1 | Bus driver enable |
| ser_out_lo | output | 1 | Bit 0 of the word |
| ser_out_hi | output | 1 | Bit 7 of the word |

## Verification
bus_oe depends only on the enables and selects, so the bench checks it in the same half-cycle the inputs change. A new word appears on bus_out and the serial outputs one rising edge after the select is applied. Inputs change on the falling edge, and every output is sampled one nanosecond after the next rising edge. Reset is checked twice. The cleared word is checked a fraction of a cycle after rst_n falls, before any edge. After release, the bench checks that the second rising edge still leaves the word cleared and that the third edge loads it.

// File: rtl/ushreg_pkg.sv
package ushreg_pkg;
  typedef enum logic [1:0] {
    MODE_KEEP = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } shmode_e;
endpackage

// File: rtl/ushreg_rst_sync.sv
module ushreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_int_n = chain_q[STAGES-1];

  // R5: internal reset follows the external one down at once
  a_r5_sync_low: assert property (@(posedge clk) !rst_n |-> !rst_int_n);
endmodule

// File: rtl/ushreg_core.sv
module ushreg_core
  import ushreg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_int_n,
  input  shmode_e      mode,
  input  logic         ser_in_lo,
  input  logic         ser_in_hi,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] word_q
);
  localparam int MSB = W - 1;

  logic [W-1:0] below;   // neighbour feeding each bit when shifting up
  logic [W-1:0] above;   // neighbour feeding each bit when shifting down
  logic [W-1:0] word_d;
  logic         word_en;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign below[i] = ser_in_lo;
    end else begin : g_lo_nb
      assign below[i] = word_q[i-1];
    end
    if (i == MSB) begin : g_msb
      assign above[i] = ser_in_hi;
    end else begin : g_hi_nb
      assign above[i] = word_q[i+1];
    end
  end

  always_comb begin
    word_en = (mode != MODE_KEEP);
    unique case (mode)
      MODE_UP:   word_d = below;
      MODE_DOWN: word_d = above;
      MODE_LOAD: word_d = load_val;
      default:   word_d = word_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  a_r1_keep: assert property (@(posedge clk) disable iff (!rst_int_n)
    mode == MODE_KEEP |=> $stable(word_q));
  a_r2_up: assert property (@(posedge clk) disable iff (!rst_int_n)
    mode == MODE_UP |=> (word_q[0] == $past(ser_in_lo)) && (word_q[MSB:1] == $past(word_q[MSB-1:0])));
  a_r3_down: assert property (@(posedge clk) disable iff (!rst_int_n)
    mode == MODE_DOWN |=> (word_q[MSB] == $past(ser_in_hi)) && (word_q[MSB-1:0] == $past(word_q[MSB:1])));
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_int_n)
    mode == MODE_LOAD |=> word_q == $past(load_val));
  a_r5_clear: assert property (@(posedge clk) !rst_int_n |-> word_q == '0);
endmodule

// File: rtl/ushreg_drive.sv
module ushreg_drive
  import ushreg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  shmode_e      mode,
  input  logic         oe_a_n,
  input  logic         oe_b_n,
  input  logic [W-1:0] word_q,
  output logic [W-1:0] bus_out,
  output logic         bus_oe
);
  logic pins_on;

  always_comb begin
    pins_on = !oe_a_n && !oe_b_n;
    bus_oe  = pins_on && (mode != MODE_LOAD);
    bus_out = bus_oe ? word_q : '0;
  end

  a_r6_off_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_LOAD |-> !bus_oe);
  a_r6_off_by_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_a_n || oe_b_n) |-> !bus_oe);
  a_r7_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> bus_out == '0);
endmodule

// File: rtl/ushreg_bus.sv
module ushreg_bus
  import ushreg_pkg::*;
#(
  parameter int W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_lo,
  input  logic         sel_hi,
  input  logic         ser_in_lo,
  input  logic         ser_in_hi,
  input  logic         oe_a_n,
  input  logic         oe_b_n,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  output logic         ser_out_lo,
  output logic         ser_out_hi
);
  localparam int MSB = W - 1;

  shmode_e      mode;
  logic         rst_int_n;
  logic [W-1:0] word_q;

  assign mode = shmode_e'({sel_hi, sel_lo});

  ushreg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  ushreg_core #(.W(W)) u_core (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .mode      (mode),
    .ser_in_lo (ser_in_lo),
    .ser_in_hi (ser_in_hi),
    .load_val  (bus_in),
    .word_q    (word_q)
  );

  ushreg_drive #(.W(W)) u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .oe_a_n  (oe_a_n),
    .oe_b_n  (oe_b_n),
    .word_q  (word_q),
    .bus_out (bus_out),
    .bus_oe  (bus_oe)
  );

  assign ser_out_lo = word_q[0];
  assign ser_out_hi = word_q[MSB];

  // R9: end bits seen on the bus match the serial outputs
  a_r9_ends_match: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (ser_out_lo == bus_out[0]) && (ser_out_hi == bus_out[MSB]));
endmodule

// File: tb/ushreg_bus_test.sv
module ushreg_bus_test;
  typedef struct packed {
    logic [1:0] sel;
    logic       slo;
    logic       shi;
    logic       oea;
    logic       oeb;
    logic [7:0] din;
    logic [7:0] expq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5},
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hA5},
    '{2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h4B},
    '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h96},
    '{2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'hCB},
    '{2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h65},
    '{2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h65},
    '{2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'hCA},
    '{2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 8'h3C, 8'h3C},
    '{2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h9E},
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h9E},
    '{2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF},
    '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFE},
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFE}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       slo = 1'b0, shi = 1'b0, oea = 1'b0, oeb = 1'b0;
  logic [7:0] din = 8'h00, din_hi = 8'h00;
  logic       casc = 1'b0;
  logic [7:0] bout, bout_hi;
  logic       boe, boe_hi, so_lo, so_hi, hso_lo, hso_hi;
  logic       lo_sin_hi;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  assign lo_sin_hi = casc ? hso_lo : shi;

  ushreg_bus uut (
    .clk(clk), .rst_n(rst_n), .sel_lo(sel[0]), .sel_hi(sel[1]),
    .ser_in_lo(slo), .ser_in_hi(lo_sin_hi), .oe_a_n(oea), .oe_b_n(oeb),
    .bus_in(din), .bus_out(bout), .bus_oe(boe),
    .ser_out_lo(so_lo), .ser_out_hi(so_hi)
  );

  ushreg_bus uut_hi (
    .clk(clk), .rst_n(rst_n), .sel_lo(sel[0]), .sel_hi(sel[1]),
    .ser_in_lo(so_hi), .ser_in_hi(shi), .oe_a_n(oea), .oe_b_n(oeb),
    .bus_in(din_hi), .bus_out(bout_hi), .bus_oe(boe_hi),
    .ser_out_lo(hso_lo), .ser_out_hi(hso_hi)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] s, input logic l, input logic h,
                       input logic a, input logic b, input logic [7:0] d);
    @(negedge clk);
    sel = s; slo = l; shi = h; oea = a; oeb = b; din = d;
  endtask

  task automatic edge_sample();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) edge_sample();
    // R5: state after reset, read through the bus in hold mode
    check("R5 reset word", {8'h00, bout}, 16'h0000);
    check("R6 enabled in hold", {15'h0, boe}, 16'h0001);

    // table walk
    for (int k = 0; k < NV; k++) begin
      logic eoe;
      string tg;
      drive(VEC[k].sel, VEC[k].slo, VEC[k].shi, VEC[k].oea, VEC[k].oeb, VEC[k].din);
      eoe = !VEC[k].oea && !VEC[k].oeb && (VEC[k].sel != 2'b11);
      #0.5;
      check("R6 bus_oe from inputs", {15'h0, boe}, {15'h0, eoe});
      edge_sample();
      case (VEC[k].sel)
        2'b00:   tg = "R1 keep";
        2'b01:   tg = "R2 shift up";
        2'b10:   tg = "R3 shift down";
        default: tg = "R4 load";
      endcase
      if (VEC[k].oea || VEC[k].oeb) tg = {tg, " R8 drivers off"};
      check({tg, " R7 bus_out"}, {8'h00, bout}, {8'h00, eoe ? VEC[k].expq : 8'h00});
      check({tg, " R9 serial ends"}, {14'h0, so_hi, so_lo}, {14'h0, VEC[k].expq[7], VEC[k].expq[0]});
    end

    // R5: reset in the middle of a cycle, overriding the selects and clock
    drive(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5);
    edge_sample();
    rst_n = 1'b0;
    #0.5;
    check("R5 cleared before next edge", {14'h0, so_hi, so_lo}, 16'h0000);
    din = 8'hFF;
    repeat (2) edge_sample();
    check("R5 load ignored in reset", {14'h0, so_hi, so_lo}, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) edge_sample();
    check("R5 still clear at edge two", {14'h0, so_hi, so_lo}, 16'h0000);
    edge_sample();
    check("R5 third edge loads", {14'h0, so_hi, so_lo}, 16'h0003);
    drive(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    edge_sample();
    check("R4 loaded word after reset", {8'h00, bout}, 16'h00FF);

    // R8: reset while drivers are off still clears the word
    drive(2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
    #0.5 rst_n = 1'b0;
    #1 rst_n = 1'b1;
    drive(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    repeat (3) edge_sample();
    check("R8 reset with drivers off", {8'h00, bout}, 16'h0000);

    // R10: two registers chained as a sixteen-bit word
    casc = 1'b1;
    din_hi = 8'h00;
    drive(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81);
    edge_sample();
    drive(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    edge_sample();
    check("R10 chain up one", {bout_hi, bout}, 16'h0102);
    for (int j = 0; j < 7; j++) edge_sample();
    drive(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    edge_sample();
    check("R10 chain up eight", {bout_hi, bout}, 16'h8100);
    drive(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    for (int j = 0; j < 4; j++) edge_sample();
    drive(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    edge_sample();
    check("R10 chain down four", {bout_hi, bout}, 16'hF810);
    check("R9 chain serial ends", {12'h0, hso_hi, hso_lo, so_hi, so_lo}, 16'h0008);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule